// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block drives an I2C bus as the only master and sends bytes to a slave. Software works it through strobes that behave like register accesses. A start request produces a START condition. A status-0 read followed by a data write sends the address byte. If that byte is a 10-bit header (top five bits `11110`), the block sends it and then waits for a second read-then-write, which sends the low address byte. Once the address is acknowledged, a status-0 read followed by a status-1 read opens the data phase.

In the data phase a one-byte holding register sits in front of the shift register. Software keeps feeding bytes while transmit-empty is high. When the shift register is idle and the holding register is also empty, byte-transfer-complete is raised. A stop request then ends the transfer with a STOP condition.

SCL and SDA are driven as open-drain: an output at 1 pulls the line low. A quarter of every SCL bit period lasts `CLK_DIV` system clocks.

Top module: `i2cm_tx`

## Requirements
- R1: After reset both bus drivers are released (`scl_low_o`=0, `sda_low_o`=0), and `master_o` and all six flags are 0.
- R2: A start request while idle makes SDA fall while SCL is released, then pulls SCL low, sets `flag_sb` and sets `master_o`.
- R3: `flag_sb` clears only on a `data_wr` that follows a `stat0_rd`, and that write starts the address byte. A `data_wr` without a preceding `stat0_rd` leaves `flag_sb` set and sends nothing.
- R4: A first address byte whose bits [7:3] are `11110` is a 10-bit header. Once it is acknowledged, `flag_hdr` sets and `flag_addr` stays 0. A `stat0_rd` followed by a `data_wr` clears `flag_hdr` and sends the lower address byte.
- R5: Once the final address byte is acknowledged, `flag_addr` sets. It clears only on a `stat1_rd` that follows a `stat0_rd`, and a lone `stat1_rd` leaves it set. At most one of `flag_sb`, `flag_hdr` and `flag_addr` is high at any time.
- R6: Clearing `flag_addr` enters the data phase with `flag_txe`=1 and `flag_btc`=0.
- R7: In the data phase, a write while the shift register is empty loads the shift register directly and `flag_txe` stays 1. A write while a byte is still shifting fills the holding register and clears `flag_txe`.
- R8: Every byte is sent MSB first, with the ACK bit on the ninth SCL pulse. During bytes, SDA changes only while SCL is low, so each transfer shows exactly one START and one STOP.
- R9: When an acknowledged byte ends and the holding register is empty, `flag_btc` sets and SCL stays low. `flag_txe` is 1 whenever `flag_btc` is 1.
- R10: A stop request in the data phase produces a STOP (SDA rises while SCL is released). After the STOP, `flag_txe`, `flag_btc` and `master_o` are 0 and both lines are released.
- R11: A NACK on any byte sets `flag_af`. No further byte is loaded or sent until the next START, and `flag_btc` stays 0.
- R12: SCL stays released for exactly 2×`CLK_DIV` system clocks on each data or ACK pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request a START (taken only while idle) |
| stop_req | input | 1 | Request a STOP (data phase or after NACK) |
| stat0_rd | input | 1 | Status register 0 read strobe |
| stat1_rd | input | 1 | Status register 1 read strobe |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 8 | Byte written with `data_wr` |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_low_o | output | 1 | 1 pulls SCL low |
| sda_low_o | output | 1 | 1 pulls SDA low |
| flag_sb | output | 1 | START has been sent |
| flag_hdr | output | 1 | 10-bit header has been sent |
| flag_addr | output | 1 | Address has been sent and acknowledged |
| flag_txe | output | 1 | Transmit holding register is empty |
| flag_btc | output | 1 | Byte transfer is complete, both stages empty |
| flag_af | output | 1 | Acknowledge failure |
| master_o | output | 1 | Block owns the bus |

## Verification
The bound checker watches these rules on every clock:
- SDA holds steady while SCL is high inside a byte.
- Each address-stage flag falls only on the strobe that is allowed to clear it, and at most one of them is high.
- Byte-complete is never high without transmit-empty.
- No load happens after an acknowledge failure.
- The flags and lines are released right after a STOP.

Several behaviours need the bench's slave model instead:
- the byte order on the wire;
- the count of START and STOP conditions;
- the SCL high time;
- the strobe sequences that must leave a flag untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_HOLD,
    S_BITS,
    S_STOP
  } eng_t;

  // a first address byte with top bits 11110 announces a 10-bit address
  function automatic logic is_hdr10(input logic [7:0] b);
    return b[7:3] == 5'b11110;
  endfunction

  // SDA pull for a bit slot: data slots drive the inverted MSB, the ACK slot releases
  function automatic logic bit_pull(input logic [7:0] sh, input logic [3:0] idx);
    return (idx == 4'd8) ? 1'b0 : ~sh[7];
  endfunction
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rd0,
  input  logic rd1,
  input  logic wr,
  input  logic start_done,
  input  logic addr_done,
  input  logic ack_ok,
  input  logic cur_hdr,
  input  logic nack_evt,
  input  logic clr_af,
  output logic sb,
  output logic hdr,
  output logic adr,
  output logic af,
  output logic load_addr,
  output logic enter_data
);
  logic arm;

  assign load_addr  = wr && arm && (sb || hdr);
  assign enter_data = rd1 && arm && adr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm <= 1'b0; sb <= 1'b0; hdr <= 1'b0; adr <= 1'b0; af <= 1'b0;
    end else begin
      if (rd0) arm <= 1'b1;
      else if (wr || rd1) arm <= 1'b0;
      if (start_done) sb <= 1'b1;
      else if (load_addr && sb) sb <= 1'b0;
      if (addr_done && ack_ok && cur_hdr) hdr <= 1'b1;
      else if (load_addr && hdr) hdr <= 1'b0;
      if (addr_done && ack_ok && !cur_hdr) adr <= 1'b1;
      else if (enter_data) adr <= 1'b0;
      if (nack_evt) af <= 1'b1;
      else if (clr_af) af <= 1'b0;
    end
endmodule

// File: rtl/i2cm_tx.sv
module i2cm_tx
  import i2cm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       stat0_rd,
  input  logic       stat1_rd,
  input  logic       data_wr,
  input  logic [7:0] data_in,
  input  logic       sda_in,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       flag_sb,
  output logic       flag_hdr,
  output logic       flag_addr,
  output logic       flag_txe,
  output logic       flag_btc,
  output logic       flag_af,
  output logic       master_o
);
  eng_t       st;
  logic [1:0] q;
  logic [3:0] bidx;
  logic [7:0] shreg, dreg;
  logic       sh_full, dvalid, in_data, cur_hdr, start_pend, stop_pend, ack_ok;
  logic       tick, load_addr, enter_data;

  // named internal events
  logic start_done, samp_ack, byte_end, nack_evt, addr_done, stop_done;
  logic dwr, xfer_end, sh_load, in_bits;

  assign start_done = tick && st == S_START;
  assign samp_ack   = tick && st == S_BITS && q == 2'd2 && bidx == 4'd8;
  assign byte_end   = tick && st == S_BITS && q == 2'd3 && bidx == 4'd8;
  assign nack_evt   = byte_end && !ack_ok;
  assign addr_done  = byte_end && !in_data;
  assign stop_done  = tick && st == S_STOP && q == 2'd2;
  assign dwr        = data_wr && in_data && !flag_af;
  assign xfer_end   = byte_end && in_data && ack_ok;
  assign sh_load    = load_addr || (dwr && !sh_full) || (xfer_end && (dvalid || dwr));
  assign in_bits    = st == S_BITS;
  assign master_o   = st != S_IDLE;

  i2cm_qtick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  i2cm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .rd0(stat0_rd), .rd1(stat1_rd), .wr(data_wr),
    .start_done(start_done), .addr_done(addr_done), .ack_ok(ack_ok),
    .cur_hdr(cur_hdr), .nack_evt(nack_evt), .clr_af(start_req && st == S_IDLE),
    .sb(flag_sb), .hdr(flag_hdr), .adr(flag_addr), .af(flag_af),
    .load_addr(load_addr), .enter_data(enter_data)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; q <= 2'd0; bidx <= 4'd0; shreg <= 8'h00; dreg <= 8'h00;
      sh_full <= 1'b0; dvalid <= 1'b0; in_data <= 1'b0; cur_hdr <= 1'b0;
      start_pend <= 1'b0; stop_pend <= 1'b0; ack_ok <= 1'b0;
      scl_low_o <= 1'b0; sda_low_o <= 1'b0; flag_txe <= 1'b0; flag_btc <= 1'b0;
    end else begin
      if (start_req && st == S_IDLE) start_pend <= 1'b1;
      if (stop_req && st != S_IDLE && (in_data || flag_af)) stop_pend <= 1'b1;
      if (samp_ack) ack_ok <= ~sda_in;

      // bus engine, one step per quarter bit
      if (tick) begin
        unique case (st)
          S_IDLE: begin
            scl_low_o <= 1'b0;
            sda_low_o <= 1'b0;
            if (start_pend) begin
              sda_low_o  <= 1'b1;
              start_pend <= 1'b0;
              st         <= S_START;
            end
          end
          S_START: begin
            scl_low_o <= 1'b1;
            st        <= S_HOLD;
          end
          S_HOLD: begin
            if (sh_full && !flag_af) begin
              sda_low_o <= bit_pull(shreg, 4'd0);
              bidx      <= 4'd0;
              q         <= 2'd1;
              st        <= S_BITS;
            end else if (stop_pend && (!dvalid || flag_af)) begin
              sda_low_o <= 1'b1;
              q         <= 2'd1;
              st        <= S_STOP;
            end
          end
          S_BITS: begin
            unique case (q)
              2'd0: begin sda_low_o <= bit_pull(shreg, bidx); q <= 2'd1; end
              2'd1: begin scl_low_o <= 1'b0; q <= 2'd2; end
              2'd2: q <= 2'd3;
              2'd3: begin
                scl_low_o <= 1'b1;
                q         <= 2'd0;
                if (bidx == 4'd8) st <= S_HOLD;
                else begin
                  bidx  <= bidx + 4'd1;
                  shreg <= shreg << 1;
                end
              end
            endcase
          end
          S_STOP: begin
            if (q == 2'd1) begin
              scl_low_o <= 1'b0;
              q         <= 2'd2;
            end else begin
              sda_low_o <= 1'b0;
              st        <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end

      // two-stage transmit buffer
      if (byte_end) sh_full <= 1'b0;
      if (load_addr) begin
        shreg   <= data_in;
        sh_full <= 1'b1;
        cur_hdr <= flag_sb && is_hdr10(data_in);
      end else if (dwr && !sh_full) begin
        shreg    <= data_in;
        sh_full  <= 1'b1;
        flag_btc <= 1'b0;
      end else if (xfer_end && dvalid) begin
        shreg    <= dreg;
        sh_full  <= 1'b1;
        dvalid   <= 1'b0;
        flag_txe <= 1'b1;
      end else if (xfer_end && dwr) begin
        shreg    <= data_in;
        sh_full  <= 1'b1;
        flag_txe <= 1'b1;
      end else if (xfer_end) begin
        flag_btc <= 1'b1;
      end else if (dwr && sh_full && !dvalid) begin
        dreg     <= data_in;
        dvalid   <= 1'b1;
        flag_txe <= 1'b0;
      end

      if (enter_data) begin
        in_data  <= 1'b1;
        flag_txe <= 1'b1;
        flag_btc <= 1'b0;
      end
      if (stop_done) begin
        in_data   <= 1'b0;
        flag_txe  <= 1'b0;
        flag_btc  <= 1'b0;
        dvalid    <= 1'b0;
        stop_pend <= 1'b0;
      end
    end
endmodule

// File: rtl/i2cm_tx_chk.sv
module i2cm_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic in_bits,
  input logic flag_sb,
  input logic flag_hdr,
  input logic flag_addr,
  input logic flag_txe,
  input logic flag_btc,
  input logic flag_af,
  input logic data_wr,
  input logic stat1_rd,
  input logic stop_done,
  input logic sh_load
);
  p_sda_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bits && $past(in_bits) && !scl_low_o && !$past(scl_low_o)) |-> $stable(sda_low_o));

  p_sb_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_sb) |-> $past(data_wr));

  p_hdr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_hdr) |-> $past(data_wr));

  p_addr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_addr) |-> $past(stat1_rd));

  p_addr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_sb, flag_hdr, flag_addr}));

  p_btc_txe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_btc |-> flag_txe);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> (!flag_txe && !flag_btc && !scl_low_o && !sda_low_o));

  p_af_noload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_af |-> !sh_load);
endmodule

bind i2cm_tx i2cm_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
  .in_bits(in_bits), .flag_sb(flag_sb), .flag_hdr(flag_hdr), .flag_addr(flag_addr),
  .flag_txe(flag_txe), .flag_btc(flag_btc), .flag_af(flag_af), .data_wr(data_wr),
  .stat1_rd(stat1_rd), .stop_done(stop_done), .sh_load(sh_load)
);

// File: tb/i2cm_tx_test.sv
module i2cm_tx_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, stat0_rd = 1'b0, stat1_rd = 1'b0, data_wr = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic scl_low_o, sda_low_o, flag_sb, flag_hdr, flag_addr, flag_txe, flag_btc, flag_af, master_o;
  logic pull = 1'b0, nack = 1'b0;
  wire  bus_scl = ~scl_low_o;
  wire  bus_sda = ~(sda_low_o | pull);

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  i2cm_tx #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .stat0_rd(stat0_rd), .stat1_rd(stat1_rd), .data_wr(data_wr), .data_in(data_in),
    .sda_in(bus_sda), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .flag_sb(flag_sb),
    .flag_hdr(flag_hdr), .flag_addr(flag_addr), .flag_txe(flag_txe), .flag_btc(flag_btc),
    .flag_af(flag_af), .master_o(master_o)
  );

  // slave model: records START, STOP and bytes MSB first, drives the ACK
  int starts = 0, stops = 0, bitn = 0, rxn = 0;
  logic [7:0] sr = 8'h00;
  logic [7:0] rx [0:15];
  logic p_scl = 1'b1, p_sda = 1'b1;
  always @(bus_scl or bus_sda) begin
    if (bus_scl && p_scl && bus_sda != p_sda) begin
      if (!bus_sda) begin starts++; bitn = 0; end
      else stops++;
    end else if (bus_scl && !p_scl) begin
      sr = {sr[6:0], bus_sda};
      bitn++;
      if (bitn == 8 && rxn < 16) begin rx[rxn] = sr; rxn++; end
    end else if (!bus_scl && p_scl) begin
      if (bitn == 8) pull = !nack;
      else if (bitn == 9) begin pull = 1'b0; bitn = 0; end
    end
    p_scl = bus_scl;
    p_sda = bus_sda;
  end

  // SCL high-time meter
  int hi_cnt = 0, last_hi = 0;
  always @(posedge clk) begin
    if (bus_scl) hi_cnt++;
    else if (hi_cnt != 0) begin last_hi = hi_cnt; hi_cnt = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // 0 start, 1 stop, 2 read0, 3 read1, 4 write
  task automatic strobe(input int which, input logic [7:0] d);
    @(negedge clk);
    data_in = d;
    case (which)
      0: start_req = 1'b1;
      1: stop_req  = 1'b1;
      2: stat0_rd  = 1'b1;
      3: stat1_rd  = 1'b1;
      default: data_wr = 1'b1;
    endcase
    @(negedge clk);
    start_req = 1'b0; stop_req = 1'b0; stat0_rd = 1'b0; stat1_rd = 1'b0; data_wr = 1'b0;
  endtask

  function automatic logic get_flag(input int w);
    case (w)
      0: return flag_sb;
      1: return flag_hdr;
      2: return flag_addr;
      3: return flag_btc;
      4: return flag_af;
      default: return master_o;
    endcase
  endfunction

  task automatic wait_flag(input int w, input logic val, input string req);
    int n = 0;
    while (get_flag(w) !== val && n < 5000) begin @(negedge clk); n++; end
    chk(req, {31'd0, get_flag(w)}, {31'd0, val});
  endtask

  task automatic t_reset;
    chk("R1 scl", scl_low_o, 0);
    chk("R1 sda", sda_low_o, 0);
    chk("R1 flags", {flag_sb, flag_hdr, flag_addr, flag_txe, flag_btc, flag_af, master_o}, 0);
  endtask

  task automatic t_seven_bit;
    strobe(0, 8'h00);
    wait_flag(0, 1'b1, "R2 sb set");
    chk("R2 one START", starts, 1);
    chk("R2 master", master_o, 1);
    strobe(4, 8'hA4);                       // write with no status-0 read first
    repeat (100) @(negedge clk);
    chk("R3 sb held", flag_sb, 1);
    chk("R3 nothing sent", rxn, 0);
    strobe(2, 8'h00);
    strobe(4, 8'hA4);
    chk("R3 sb cleared", flag_sb, 0);
    wait_flag(2, 1'b1, "R5 addr set");
    chk("R8 addr byte", rx[0], 8'hA4);
    strobe(3, 8'h00);                       // lone status-1 read
    chk("R5 addr held", flag_addr, 1);
    strobe(2, 8'h00);
    strobe(3, 8'h00);
    chk("R5 addr cleared", flag_addr, 0);
    chk("R6 txe", flag_txe, 1);
    chk("R6 btc", flag_btc, 0);
    strobe(4, 8'h5A);
    chk("R7 txe kept", flag_txe, 1);
    strobe(4, 8'hC3);
    chk("R7 txe cleared", flag_txe, 0);
    wait_flag(3, 1'b1, "R9 btc set");
    chk("R9 txe with btc", flag_txe, 1);
    chk("R9 scl held low", scl_low_o, 1);
    chk("R8 byte1 MSB first", rx[1], 8'h5A);
    chk("R8 byte2 MSB first", rx[2], 8'hC3);
    chk("R12 scl high time", last_hi, 2 * DIV);
    strobe(1, 8'h00);
    wait_flag(5, 1'b0, "R10 master released");
    chk("R10 one STOP", stops, 1);
    chk("R8 single START", starts, 1);
    chk("R10 txe btc", {flag_txe, flag_btc}, 0);
    chk("R10 lines", {scl_low_o, sda_low_o}, 0);
  endtask

  task automatic t_ten_bit;
    int base = rxn;
    strobe(0, 8'h00);
    wait_flag(0, 1'b1, "R2 sb set");
    strobe(2, 8'h00);
    strobe(4, 8'hF2);
    wait_flag(1, 1'b1, "R4 hdr set");
    chk("R4 addr not yet", flag_addr, 0);
    chk("R4 header byte", rx[base], 8'hF2);
    strobe(2, 8'h00);
    strobe(4, 8'h37);
    chk("R4 hdr cleared", flag_hdr, 0);
    wait_flag(2, 1'b1, "R5 addr after low byte");
    chk("R4 low byte", rx[base+1], 8'h37);
    strobe(2, 8'h00);
    strobe(3, 8'h00);
    strobe(4, 8'h99);
    wait_flag(3, 1'b1, "R9 btc set");
    chk("R8 data byte", rx[base+2], 8'h99);
    strobe(1, 8'h00);
    wait_flag(5, 1'b0, "R10 master released");
    chk("R10 STOP count", stops, 2);
  endtask

  task automatic t_nack;
    int base = rxn;
    strobe(0, 8'h00);
    wait_flag(0, 1'b1, "R2 sb set");
    strobe(2, 8'h00);
    strobe(4, 8'h50);
    wait_flag(2, 1'b1, "R5 addr set");
    strobe(2, 8'h00);
    strobe(3, 8'h00);
    nack = 1'b1;
    strobe(4, 8'h81);
    strobe(4, 8'h7E);
    chk("R7 held byte", flag_txe, 0);
    wait_flag(4, 1'b1, "R11 af set");
    repeat (400) @(negedge clk);
    chk("R11 no btc", flag_btc, 0);
    chk("R11 one data byte", rxn - base, 2);
    chk("R11 sent byte", rx[base+1], 8'h81);
    strobe(1, 8'h00);
    wait_flag(5, 1'b0, "R10 stop after nack");
    nack = 1'b0;
    chk("R10 STOP count", stops, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seven_bit();
    t_ten_bit();
    t_nack();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule